// File: doc/BRIEF.md
# Line and frame process-block video timer

This block derives horizontal and vertical video timing from a machine clock. The machine clock runs at 8.25 MHz, a quarter of a 33 MHz dot clock. A scan line is not set by a free pixel counter. It is a whole number of fixed-length virtual machine slots of `SLOT_CLKS` machine clocks each (43 by default), optionally followed by a few padding clocks. Consecutive lines are grouped into process blocks. The block strobe paces slower work elsewhere in the chip, such as serial line sampling and audio sample output, and it advances an external block counter exactly once per block.

Three modes are selectable through a 2-bit input:
- Mode 0: five slots per line and four lines per block, about 38.4 kHz line rate.
- Mode 1: four slots per line and five lines per block, about 48 kHz line rate.
- Mode 2: six slots per line plus `VGA_PAD` padding clocks and three lines per block, 262 clocks per line for a 60 Hz VGA-like frame.

Modes 0 and 1 both produce a 20-slot block at about 9.6 kHz. A frame is a per-mode number of blocks; mode 2 defaults to 175 blocks, which is 525 lines. A new mode request is honoured only at a frame boundary.

The outputs are the sync pulses, a blanking flag, a one-clock line strobe, a one-clock block strobe, and the line-in-frame and block-in-frame counts. Every output is registered. Each output therefore shows the timing position one clock after the internal counters reach it, and all outputs move together.

Top module: `vt_line_block_timer`

## Requirements
- R1: A line lasts 5×`SLOT_CLKS` clocks in mode 0, 4×`SLOT_CLKS` in mode 1 and 6×`SLOT_CLKS`+`VGA_PAD` in mode 2. `line_stb` is high for exactly the first clock of each line.
- R2: A block holds 4 lines in mode 0, 5 in mode 1 and 3 in mode 2. `blk_stb` is high for exactly the first clock of a block's first line, always together with `line_stb`.
- R3: A frame holds `FRAME_BLK0`/`FRAME_BLK1`/`FRAME_BLK2` blocks in modes 0/1/2. `line_cnt` gives the line index within the frame from 0. `blk_cnt` gives the block index within the frame from 0; it changes only on a `blk_stb` clock, steps by one and wraps to 0 at a new frame.
- R4: `hsync` is at level `HS_POL` while the clock position in the line is at least `HS_START` plus the mode's padding and below that plus `HS_WIDTH`. It is at the opposite level otherwise, so the padding delays the pulse.
- R5: `vsync` is at level `VS_POL` on frame lines from `VACTn`+`VS_FRONT` up to but not including `VACTn`+`VS_FRONT`+`VS_LINES`, where n is the mode. It is at the opposite level otherwise.
- R6: `blank` is 1 when the clock position in the line is at least `H_ACTIVE` or the line index is at least the mode's `VACTn`, and 0 otherwise. Neither sync pulse occurs outside blanking.
- R7: `mode_sel` is sampled only on the last clock of a frame and while reset is held. A change in the middle of a frame leaves the remaining lines of that frame at the old mode.
- R8: While `rst` is high, the outputs are idle: both syncs at their inactive levels, `blank`=1, both strobes 0 and both counts 0. On the second clock after `rst` falls, `line_stb` and `blk_stb` are 1 with both counts 0.
- R9: `mode_sel`=3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Requested mode: 0, 1, 2 (3 aliases 0) |
| hsync | output | 1 | Horizontal sync, active level `HS_POL` |
| vsync | output | 1 | Vertical sync, active level `VS_POL` |
| blank | output | 1 | 1 outside the active picture |
| line_stb | output | 1 | One-clock pulse at each line start |
| blk_stb | output | 1 | One-clock pulse at each process-block start |
| line_cnt | output | 12 | Line index within the frame |
| blk_cnt | output | 10 | Process-block index within the frame |

## Verification
The hardest case to reach is a mode request that changes within the last clock or two before a frame boundary. If it lands on the final clock it must take effect; one clock later it must wait a whole frame. The stimulus changes `mode_sel` at random points throughout long runs, with the seed fixed, so many changes fall near boundaries. The bench's model takes the requested value from the exact sampling edge, two observations back. A reset with a pending request and a run with the aliased value 3 cover the remaining entry paths into a mode.

// File: rtl/vt_pkg.sv
package vt_pkg;

    // Counter and field widths shared by all timer pieces
    localparam int HPOS_W = 12;
    localparam int LINE_W = 12;
    localparam int BLK_W  = 10;
    localparam int LPB_W  = 3;
    localparam int SPL_W  = 3;
    localparam int PAD_W  = 6;

    // Mode encodings seen on the mode_sel input
    typedef enum logic [1:0] {
        MODE_4X5   = 2'd0,
        MODE_5X4   = 2'd1,
        MODE_3X6   = 2'd2,
        MODE_ALIAS = 2'd3
    } vt_mode_e;

    // Geometry of the active mode
    typedef struct packed {
        logic [LPB_W-1:0]  lpb;   // lines per process block
        logic [SPL_W-1:0]  spl;   // slots per line
        logic [PAD_W-1:0]  pad;   // padding clocks after the slots
        logic [BLK_W-1:0]  fblk;  // blocks per frame
        logic [LINE_W-1:0] vact;  // visible lines per frame
    } vt_cfg_t;

    // Position of the raster inside the frame
    typedef struct packed {
        logic [HPOS_W-1:0] hpos;
        logic [LPB_W-1:0]  lib;
        logic [BLK_W-1:0]  blk;
        logic [LINE_W-1:0] line;
    } vt_pos_t;

    function automatic vt_mode_e vt_norm(input logic [1:0] sel);
        return (sel == 2'd3) ? MODE_4X5 : vt_mode_e'(sel);
    endfunction

    function automatic vt_cfg_t vt_pick(input vt_mode_e m,
                                        input int fb0, input int fb1, input int fb2,
                                        input int va0, input int va1, input int va2,
                                        input int pad2);
        vt_cfg_t c;
        case (m)
            MODE_5X4: begin
                c.lpb  = LPB_W'(5);
                c.spl  = SPL_W'(4);
                c.pad  = '0;
                c.fblk = BLK_W'(fb1);
                c.vact = LINE_W'(va1);
            end
            MODE_3X6: begin
                c.lpb  = LPB_W'(3);
                c.spl  = SPL_W'(6);
                c.pad  = PAD_W'(pad2);
                c.fblk = BLK_W'(fb2);
                c.vact = LINE_W'(va2);
            end
            default: begin
                c.lpb  = LPB_W'(4);
                c.spl  = SPL_W'(5);
                c.pad  = '0;
                c.fblk = BLK_W'(fb0);
                c.vact = LINE_W'(va0);
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vt_mode_latch.sv
module vt_mode_latch
    import vt_pkg::*;
#(
    parameter int FRAME_BLK0 = 157,
    parameter int FRAME_BLK1 = 160,
    parameter int FRAME_BLK2 = 175,
    parameter int VACT0      = 600,
    parameter int VACT1      = 768,
    parameter int VACT2      = 480,
    parameter int VGA_PAD    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       frame_end,
    output vt_mode_e   mode_q,
    output vt_cfg_t    cfg
);

    // The request is taken only during reset or on the last clock of a frame
    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            mode_q <= vt_norm(mode_sel);
        end
    end

    always_comb begin
        cfg = vt_pick(mode_q, FRAME_BLK0, FRAME_BLK1, FRAME_BLK2,
                      VACT0, VACT1, VACT2, VGA_PAD);
    end

endmodule

// File: rtl/vt_slot_timer.sv
module vt_slot_timer
    import vt_pkg::*;
#(
    parameter int SLOT_CLKS = 43
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPL_W-1:0]  spl,
    input  logic [PAD_W-1:0]  pad,
    output logic [HPOS_W-1:0] hpos,
    output logic              line_end
);

    localparam int SC_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    typedef enum logic {PH_SLOT, PH_PAD} ph_e;

    ph_e               ph_q;
    logic [SC_W-1:0]   sc_q;
    logic [SPL_W-1:0]  si_q;
    logic [PAD_W-1:0]  pc_q;
    logic [HPOS_W-1:0] hpos_q;

    logic slot_last;
    logic slots_done;
    logic pad_none;

    assign slot_last  = (sc_q == SC_W'(SLOT_CLKS - 1));
    assign slots_done = slot_last && (si_q == spl - SPL_W'(1));
    assign pad_none   = (pad == '0);
    assign line_end   = ((ph_q == PH_SLOT) && slots_done && pad_none) ||
                        ((ph_q == PH_PAD) && (pc_q == pad - PAD_W'(1)));
    assign hpos       = hpos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_SLOT;
            sc_q   <= '0;
            si_q   <= '0;
            pc_q   <= '0;
            hpos_q <= '0;
        end else begin
            hpos_q <= line_end ? '0 : hpos_q + 1'b1;
            case (ph_q)
                PH_SLOT: begin
                    sc_q <= slot_last ? '0 : sc_q + 1'b1;
                    if (slot_last) begin
                        if (slots_done) begin
                            si_q <= '0;
                            if (!pad_none) begin
                                ph_q <= PH_PAD;
                                pc_q <= '0;
                            end
                        end else begin
                            si_q <= si_q + 1'b1;
                        end
                    end
                end
                PH_PAD: begin
                    pc_q <= pc_q + 1'b1;
                    if (line_end) begin
                        ph_q <= PH_SLOT;
                    end
                end
                default: ph_q <= PH_SLOT;
            endcase
        end
    end

endmodule

// File: rtl/vt_frame_counter.sv
module vt_frame_counter
    import vt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [LPB_W-1:0]  lpb,
    input  logic [BLK_W-1:0]  fblk,
    output logic [LPB_W-1:0]  lib,
    output logic [BLK_W-1:0]  blk,
    output logic [LINE_W-1:0] line,
    output logic              frame_end
);

    logic [LPB_W-1:0]  lib_q;
    logic [BLK_W-1:0]  blk_q;
    logic [LINE_W-1:0] line_q;
    logic              blk_end;

    assign blk_end   = line_end && (lib_q == lpb - LPB_W'(1));
    assign frame_end = blk_end && (blk_q == fblk - BLK_W'(1));
    assign lib       = lib_q;
    assign blk       = blk_q;
    assign line      = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lib_q  <= '0;
            blk_q  <= '0;
            line_q <= '0;
        end else if (line_end) begin
            lib_q  <= blk_end ? '0 : lib_q + 1'b1;
            line_q <= frame_end ? '0 : line_q + 1'b1;
            if (frame_end) begin
                blk_q <= '0;
            end else if (blk_end) begin
                blk_q <= blk_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vt_sync_gen.sv
module vt_sync_gen
    import vt_pkg::*;
#(
    parameter int H_ACTIVE = 128,
    parameter int HS_START = 136,
    parameter int HS_WIDTH = 20,
    parameter bit HS_POL   = 1'b0,
    parameter int VS_FRONT = 1,
    parameter int VS_LINES = 3,
    parameter bit VS_POL   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  vt_pos_t           pos,
    input  vt_cfg_t           cfg,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              line_stb,
    output logic              blk_stb,
    output logic [LINE_W-1:0] line_cnt,
    output logic [BLK_W-1:0]  blk_cnt
);

    localparam int HX_W = HPOS_W + 1;
    localparam int LX_W = LINE_W + 1;

    logic [HX_W-1:0] hs_lo, hs_hi, hpos_x;
    logic [LX_W-1:0] vs_lo, vs_hi, line_x;
    logic            hs_on, vs_on, blank_d, line_start;

    always_comb begin
        hpos_x     = HX_W'(pos.hpos);
        line_x     = LX_W'(pos.line);
        hs_lo      = HX_W'(HS_START) + HX_W'(cfg.pad);
        hs_hi      = hs_lo + HX_W'(HS_WIDTH);
        vs_lo      = LX_W'(cfg.vact) + LX_W'(VS_FRONT);
        vs_hi      = vs_lo + LX_W'(VS_LINES);
        hs_on      = (hpos_x >= hs_lo) && (hpos_x < hs_hi);
        vs_on      = (line_x >= vs_lo) && (line_x < vs_hi);
        blank_d    = (hpos_x >= HX_W'(H_ACTIVE)) || (pos.line >= cfg.vact);
        line_start = (pos.hpos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync    <= ~HS_POL;
            vsync    <= ~VS_POL;
            blank    <= 1'b1;
            line_stb <= 1'b0;
            blk_stb  <= 1'b0;
            line_cnt <= '0;
            blk_cnt  <= '0;
        end else begin
            hsync    <= hs_on ? HS_POL : ~HS_POL;
            vsync    <= vs_on ? VS_POL : ~VS_POL;
            blank    <= blank_d;
            line_stb <= line_start;
            blk_stb  <= line_start && (pos.lib == '0);
            line_cnt <= pos.line;
            blk_cnt  <= pos.blk;
        end
    end

endmodule

// File: rtl/vt_line_block_timer.sv
module vt_line_block_timer
    import vt_pkg::*;
#(
    parameter int SLOT_CLKS  = 43,
    parameter int VGA_PAD    = 4,
    parameter int FRAME_BLK0 = 157,
    parameter int FRAME_BLK1 = 160,
    parameter int FRAME_BLK2 = 175,
    parameter int VACT0      = 600,
    parameter int VACT1      = 768,
    parameter int VACT2      = 480,
    parameter int H_ACTIVE   = 128,
    parameter int HS_START   = 136,
    parameter int HS_WIDTH   = 20,
    parameter bit HS_POL     = 1'b0,
    parameter int VS_FRONT   = 1,
    parameter int VS_LINES   = 3,
    parameter bit VS_POL     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              line_stb,
    output logic              blk_stb,
    output logic [LINE_W-1:0] line_cnt,
    output logic [BLK_W-1:0]  blk_cnt
);

    vt_mode_e mode_q;
    vt_cfg_t  cfg;
    vt_pos_t  pos;
    logic     line_end;
    logic     frame_end;

    vt_mode_latch #(
        .FRAME_BLK0 (FRAME_BLK0),
        .FRAME_BLK1 (FRAME_BLK1),
        .FRAME_BLK2 (FRAME_BLK2),
        .VACT0      (VACT0),
        .VACT1      (VACT1),
        .VACT2      (VACT2),
        .VGA_PAD    (VGA_PAD)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .frame_end (frame_end),
        .mode_q    (mode_q),
        .cfg       (cfg)
    );

    vt_slot_timer #(
        .SLOT_CLKS (SLOT_CLKS)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .spl      (cfg.spl),
        .pad      (cfg.pad),
        .hpos     (pos.hpos),
        .line_end (line_end)
    );

    vt_frame_counter u_frame (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .lpb       (cfg.lpb),
        .fblk      (cfg.fblk),
        .lib       (pos.lib),
        .blk       (pos.blk),
        .line      (pos.line),
        .frame_end (frame_end)
    );

    vt_sync_gen #(
        .H_ACTIVE (H_ACTIVE),
        .HS_START (HS_START),
        .HS_WIDTH (HS_WIDTH),
        .HS_POL   (HS_POL),
        .VS_FRONT (VS_FRONT),
        .VS_LINES (VS_LINES),
        .VS_POL   (VS_POL)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pos      (pos),
        .cfg      (cfg),
        .hsync    (hsync),
        .vsync    (vsync),
        .blank    (blank),
        .line_stb (line_stb),
        .blk_stb  (blk_stb),
        .line_cnt (line_cnt),
        .blk_cnt  (blk_cnt)
    );

endmodule

// File: rtl/vt_timer_chk.sv
module vt_timer_chk #(
    parameter bit HS_POL = 1'b0,
    parameter bit VS_POL = 1'b0,
    parameter int BLK_W  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             hsync,
    input logic             vsync,
    input logic             blank,
    input logic             line_stb,
    input logic             blk_stb,
    input logic [BLK_W-1:0] blk_cnt,
    input logic [1:0]       mode_q,
    input logic             frame_end
);

    // R1: the line strobe is a single-clock pulse
    p_line_stb_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        line_stb |=> !line_stb);

    // R2: a block strobe always coincides with a line strobe
    p_blk_on_line_r2: assert property (@(posedge clk) disable iff (rst)
        blk_stb |-> line_stb);

    // R3: the block count moves only on a block strobe
    p_blkcnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !blk_stb |-> (blk_cnt == $past(blk_cnt)));

    // R6: horizontal sync stays inside blanking
    p_hs_in_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (hsync == HS_POL) |-> blank);

    // R6: vertical sync stays inside blanking
    p_vs_in_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (vsync == VS_POL) |-> blank);

    // R7: the active mode changes only right after a frame's last clock
    p_mode_at_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (mode_q != $past(mode_q))) |-> $past(frame_end));

endmodule

bind vt_line_block_timer vt_timer_chk #(
    .HS_POL (HS_POL),
    .VS_POL (VS_POL),
    .BLK_W  (vt_pkg::BLK_W)
) u_vt_chk (
    .clk       (clk),
    .rst       (rst),
    .hsync     (hsync),
    .vsync     (vsync),
    .blank     (blank),
    .line_stb  (line_stb),
    .blk_stb   (blk_stb),
    .blk_cnt   (blk_cnt),
    .mode_q    (mode_q),
    .frame_end (frame_end)
);

// File: tb/vt_line_block_timer_bench.sv
`timescale 1ns/1ps
module vt_line_block_timer_bench;

    localparam int  SLOT     = 43;
    localparam int  PAD2     = 4;
    localparam int  FB0      = 4;
    localparam int  FB1      = 3;
    localparam int  FB2      = 5;
    localparam int  VA0      = 12;
    localparam int  VA1      = 10;
    localparam int  VA2      = 12;
    localparam int  HACT     = 128;
    localparam int  HSS      = 136;
    localparam int  HSW      = 20;
    localparam bit  HSP      = 1'b0;
    localparam int  VSF      = 1;
    localparam int  VSL      = 2;
    localparam bit  VSP      = 1'b0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'd3;
    logic        hsync, vsync, blank, line_stb, blk_stb;
    logic [11:0] line_cnt;
    logic [9:0]  blk_cnt;

    always #2.5 clk = ~clk;

    vt_line_block_timer #(
        .SLOT_CLKS (SLOT), .VGA_PAD (PAD2),
        .FRAME_BLK0 (FB0), .FRAME_BLK1 (FB1), .FRAME_BLK2 (FB2),
        .VACT0 (VA0), .VACT1 (VA1), .VACT2 (VA2),
        .H_ACTIVE (HACT), .HS_START (HSS), .HS_WIDTH (HSW), .HS_POL (HSP),
        .VS_FRONT (VSF), .VS_LINES (VSL), .VS_POL (VSP)
    ) u_vt_line_block_timer (
        .clk (clk), .rst (rst), .mode_sel (mode_sel),
        .hsync (hsync), .vsync (vsync), .blank (blank),
        .line_stb (line_stb), .blk_stb (blk_stb),
        .line_cnt (line_cnt), .blk_cnt (blk_cnt)
    );

    int vectors = 0;
    int misses  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected geometry per mode, written from the requirements
    function automatic int e_norm(input int s);  return (s == 3) ? 0 : s; endfunction
    function automatic int e_len(input int m);
        return (m == 1) ? 4*SLOT : (m == 2) ? 6*SLOT + PAD2 : 5*SLOT;
    endfunction
    function automatic int e_lpb(input int m);  return (m == 1) ? 5 : (m == 2) ? 3 : 4; endfunction
    function automatic int e_fb(input int m);   return (m == 1) ? FB1 : (m == 2) ? FB2 : FB0; endfunction
    function automatic int e_vact(input int m); return (m == 1) ? VA1 : (m == 2) ? VA2 : VA0; endfunction
    function automatic int e_pad(input int m);  return (m == 2) ? PAD2 : 0; endfunction

    // Bench model state
    bit synced = 1'b0;
    int mcfg = 0, mraw = 0, lcfg = 0, lraw = 0;
    int ln = 0, hp = 0;
    int hist1 = 3, hist2 = 3;

    task automatic check_cycle();
        int  lpb = e_lpb(lcfg);
        int  lo  = HSS + e_pad(lcfg);
        int  vlo = e_vact(lcfg) + VSF;
        bit  exp_blk = (hp == 0) && (ln % lpb == 0);
        bit  exp_hs  = (hp >= lo && hp < lo + HSW) ? HSP : ~HSP;
        bit  exp_vs  = (ln >= vlo && ln < vlo + VSL) ? VSP : ~VSP;
        bit  exp_bl  = (hp >= HACT) || (ln >= e_vact(lcfg));
        chk(blk_stb == exp_blk, "R2 blk_stb", int'(blk_stb), int'(exp_blk));
        chk(line_cnt == 12'(ln), "R3 line_cnt", int'(line_cnt), ln);
        chk(blk_cnt == 10'(ln / lpb), "R3 blk_cnt", int'(blk_cnt), ln / lpb);
        chk(hsync == exp_hs, "R4 hsync", int'(hsync), int'(exp_hs));
        chk(vsync == exp_vs, "R5 vsync", int'(vsync), int'(exp_vs));
        chk(blank == exp_bl, "R6 blank", int'(blank), int'(exp_bl));
    endtask

    always @(negedge clk) begin
        if (rst) begin
            synced = 1'b0;
        end else if (!synced) begin
            if (line_stb) begin
                synced = 1'b1;
                mraw = hist2; mcfg = e_norm(hist2);
                lcfg = mcfg;  lraw = mraw;
                ln = 0; hp = 0;
                check_cycle();
            end
        end else begin
            if (line_stb) begin
                // R9 tag when the frame came from the alias code, R7 while a change is pending
                string tag = (lraw == 3) ? "R9 line length" :
                             (e_norm(int'(mode_sel)) != lcfg) ? "R7 line length" : "R1 line length";
                chk(hp + 1 == e_len(lcfg), tag, hp + 1, e_len(lcfg));
                ln++;
                if (ln == e_lpb(mcfg) * e_fb(mcfg)) begin
                    ln = 0;
                    mraw = hist2;
                    mcfg = e_norm(hist2);
                end
                hp = 0; lcfg = mcfg; lraw = mraw;
            end else begin
                hp++;
                if (hp == e_len(lcfg)) chk(1'b0, "R1 missing line_stb", hp, e_len(lcfg));
            end
            check_cycle();
        end
        hist2 = hist1;
        hist1 = int'(mode_sel);
    end

    task automatic check_idle();
        chk(hsync == ~HSP, "R8 hsync idle", int'(hsync), int'(~HSP));
        chk(vsync == ~VSP, "R8 vsync idle", int'(vsync), int'(~VSP));
        chk(blank == 1'b1, "R8 blank idle", int'(blank), 1);
        chk(line_stb == 1'b0, "R8 line_stb idle", int'(line_stb), 0);
        chk(blk_stb == 1'b0, "R8 blk_stb idle", int'(blk_stb), 0);
        chk(line_cnt == '0, "R8 line_cnt idle", int'(line_cnt), 0);
        chk(blk_cnt == '0, "R8 blk_cnt idle", int'(blk_cnt), 0);
    endtask

    task automatic release_and_check();
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(line_stb == 1'b0, "R8 first clock", int'(line_stb), 0);
        @(negedge clk);
        chk(line_stb == 1'b1 && blk_stb == 1'b1, "R8 first strobe", int'(line_stb), 1);
        chk(line_cnt == '0 && blk_cnt == '0, "R8 first counts", int'(line_cnt), 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_idle();
        release_and_check();
        // Alias code 3 held over more than a whole frame
        repeat (4500) @(posedge clk);
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #1 mode_sel = 2'($urandom % 4);
            repeat (600 + ($urandom % 3000)) @(posedge clk);
        end
        // Reset again with a new request pending
        @(posedge clk); #1 rst = 1'b1; mode_sel = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle();
        release_and_check();
        repeat (3000) @(posedge clk);
        // Directed change a few clocks before a frame ends: wait for frame start
        @(negedge clk);
        while (!(line_stb && line_cnt == '0)) @(negedge clk);
        repeat (e_lpb(1) * e_fb(1) * e_len(1) - 3) @(posedge clk);
        #1 mode_sel = 2'd2;
        repeat (2 * 15 * e_len(2)) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule